// File: doc/BRIEF.md
# Abstract Command Busy Timer

This block holds the busy flag and the error field that a debugger sees for an abstract command in a debug module. When a command is accepted, the block raises a go request towards the selected hart and sets busy. Busy does not drop when the hart finishes. Two conditions must both hold first. The selected hart must have reported completion after it took its go request. A programmable number of JTAG Run-Test/Idle ticks must also have passed since the launch.

The tick count lets a debug probe be tested against slow hardware: the probe has to keep the TAP idling, and it has to poll busy until the flag clears. A launch is refused while an error code is pending. A launch attempt made while busy records a busy error. Software clears error bits by writing ones to them. Command decoding and the program buffer sit outside this block.

Top module: `abscmd_busy_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears busy, all go requests, the error field, the completion record and the tick counter.
- R2: A `launch` strobe seen while busy is low and the error field is zero is accepted. After that edge, busy is 1 and `go_req` bit `hart_sel` is 1. The tick counter is loaded with `tick_cfg` and the completion record is cleared.
- R3: While the error field is nonzero, a `launch` strobe is refused and busy and `go_req` stay unchanged.
- R4: A `launch` strobe seen while busy is high and the error field is zero sets the error field to 1, the busy error code. The running command keeps its go requests, tick counter and busy flag.
- R5: A 1 on `go_ack` bit h clears go request h at the next edge. If the same hart is launched in that cycle, the launch wins and the request stays set.
- R6: Completion is recorded only while busy, when `done_valid` is high and `done_hart` equals the current `hart_sel`, and only if that hart's go request is already clear. Any other done strobe has no effect on when busy falls.
- R7: On each `idle_tick` the tick counter decrements if it is nonzero. On an `idle_tick` where the counter is 0 or 1 and completion is already recorded, busy falls at that edge. A completion and a tick in the same cycle therefore do not clear busy; the next tick does.
- R8: With `tick_cfg` equal to zero, busy falls on the first `idle_tick` after completion has been recorded.
- R9: When `err_wr` is high, every error bit whose `err_wdata` bit is 1 is cleared, and the other bits are kept.
- R10: If a busy error (R4) and an error-field write happen in the same cycle, the error field becomes 1.
- R11: When an accepted launch and an `idle_tick` fall in the same cycle, the counter takes `tick_cfg` and is not decremented. With `tick_cfg` = 2, busy then needs two more ticks after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| launch | input | 1 | Command launch strobe |
| hart_sel | input | HART_W | Currently selected hart |
| go_ack | input | NHARTS | Per-hart acknowledge that clears its go request |
| done_valid | input | 1 | Hart completion strobe |
| done_hart | input | HART_W | Hart that reports completion |
| idle_tick | input | 1 | One Run-Test/Idle tick of the TAP |
| tick_cfg | input | TICK_W | Configured number of idle ticks per command |
| err_wr | input | 1 | Write strobe for the error field |
| err_wdata | input | ERR_W | Write-one-to-clear mask for the error field |
| busy | output | 1 | Command in progress |
| go_req | output | NHARTS | Per-hart go requests |
| err | output | ERR_W | Error field |

## Verification
The collisions that matter are a launch arriving in the same cycle as an idle tick, and a busy error arriving in the same cycle as a write-one-to-clear of the error field. The bench provokes both on purpose. It also makes a completion coincide with a tick, and a launch coincide with the go acknowledge of the same hart. Each collision is judged by how many later ticks busy takes to fall, or by the error value after the edge. A behavioural reference model compared on every clock confirms the result.

// File: rtl/abscmd_busy_timer.sv
module abscmd_busy_timer #(
  parameter int NHARTS = 4,
  parameter int TICK_W = 8,
  parameter int ERR_W  = 3,
  localparam int HART_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [HART_W-1:0] hart_sel,
  input  logic [NHARTS-1:0] go_ack,
  input  logic              done_valid,
  input  logic [HART_W-1:0] done_hart,
  input  logic              idle_tick,
  input  logic [TICK_W-1:0] tick_cfg,
  input  logic              err_wr,
  input  logic [ERR_W-1:0]  err_wdata,
  output logic              busy,
  output logic [NHARTS-1:0] go_req,
  output logic [ERR_W-1:0]  err
);

  logic [TICK_W-1:0] cnt_q;
  logic              cmp_q;
  logic              busy_q;
  logic [ERR_W-1:0]  err_q;
  logic [NHARTS-1:0] go_q;

  logic accept, busy_hit, finish, tick_done;

  assign accept    = launch & ~busy_q & (err_q == '0);
  assign busy_hit  = launch &  busy_q & (err_q == '0);
  assign finish    = done_valid & busy_q & (done_hart == hart_sel) & ~go_q[done_hart];
  assign tick_done = idle_tick & busy_q & cmp_q & (cnt_q <= TICK_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cmp_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cmp_q  <= 1'b0;
      cnt_q  <= tick_cfg;
    end else begin
      if (idle_tick && cnt_q != '0) cnt_q <= cnt_q - TICK_W'(1);
      if (finish)    cmp_q  <= 1'b1;
      if (tick_done) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           err_q <= '0;
    else if (busy_hit) err_q <= ERR_W'(1);
    else if (err_wr)   err_q <= err_q & ~err_wdata;
  end

  for (genvar h = 0; h < NHARTS; h++) begin : g_go
    always_ff @(posedge clk) begin
      if (rst)                                     go_q[h] <= 1'b0;
      else if (accept && hart_sel == HART_W'(h))   go_q[h] <= 1'b1;
      else if (go_ack[h])                          go_q[h] <= 1'b0;
    end
  end

  assign busy   = busy_q;
  assign go_req = go_q;
  assign err    = err_q;

endmodule

// File: rtl/abscmd_busy_timer_chk.sv
module abscmd_busy_timer_chk #(
  parameter int NHARTS = 4,
  parameter int TICK_W = 8,
  parameter int ERR_W  = 3,
  localparam int HART_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              launch,
  input logic [HART_W-1:0] hart_sel,
  input logic [NHARTS-1:0] go_ack,
  input logic              done_valid,
  input logic [HART_W-1:0] done_hart,
  input logic              idle_tick,
  input logic [TICK_W-1:0] tick_cfg,
  input logic              err_wr,
  input logic [ERR_W-1:0]  err_wdata,
  input logic              busy,
  input logic [NHARTS-1:0] go_req,
  input logic [ERR_W-1:0]  err
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!busy && go_req == '0 && err == '0));

  // R2
  launch_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (launch && !busy && err == '0) |=> (busy && go_req[$past(hart_sel)]));

  // R3
  refuse_err_chk: assert property (@(posedge clk) disable iff (rst)
    (err != '0 && !busy) |=> !busy);

  // R4
  busy_err_chk: assert property (@(posedge clk) disable iff (rst)
    (launch && busy && err == '0) |=> (err == ERR_W'(1) && busy && go_req == $past(go_req)));

  // R7
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(idle_tick));

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (err_wr && !(launch && busy && err == '0)) |=> (err == ($past(err) & ~$past(err_wdata))));

endmodule

bind abscmd_busy_timer abscmd_busy_timer_chk #(
  .NHARTS(NHARTS), .TICK_W(TICK_W), .ERR_W(ERR_W)
) chk_i (.*);

// File: tb/abscmd_busy_timer_tb_top.sv
`timescale 1ns/1ps
module abscmd_busy_timer_tb_top;
  localparam int NH = 4;
  localparam int TW = 8;
  localparam int EW = 3;

  logic clk = 0;
  logic rst = 1;
  logic launch = 0, done_valid = 0, idle_tick = 0, err_wr = 0;
  logic [1:0] hart_sel = 0, done_hart = 0;
  logic [NH-1:0] go_ack = 0;
  logic [TW-1:0] tick_cfg = 0;
  logic [EW-1:0] err_wdata = 0;
  logic busy;
  logic [NH-1:0] go_req;
  logic [EW-1:0] err;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  abscmd_busy_timer #(.NHARTS(NH), .TICK_W(TW), .ERR_W(EW)) dut_i (
    .clk(clk), .rst(rst), .launch(launch), .hart_sel(hart_sel), .go_ack(go_ack),
    .done_valid(done_valid), .done_hart(done_hart), .idle_tick(idle_tick),
    .tick_cfg(tick_cfg), .err_wr(err_wr), .err_wdata(err_wdata),
    .busy(busy), .go_req(go_req), .err(err));

  // behavioural reference model
  bit m_busy, m_cmp;
  int m_cnt, m_err;
  bit m_go[NH];

  always @(posedge clk) begin
    bit acc, hit, fin, tdn;
    if (rst) begin
      m_busy = 0; m_cmp = 0; m_cnt = 0; m_err = 0;
      foreach (m_go[i]) m_go[i] = 0;
    end else begin
      acc = launch && !m_busy && m_err == 0;
      hit = launch && m_busy && m_err == 0;
      fin = done_valid && m_busy && done_hart == hart_sel && !m_go[done_hart];
      tdn = idle_tick && m_busy && m_cmp && m_cnt <= 1;
      foreach (m_go[i]) begin
        if (acc && int'(hart_sel) == i) m_go[i] = 1;
        else if (go_ack[i]) m_go[i] = 0;
      end
      if (hit) m_err = 1;
      else if (err_wr) m_err = m_err & ~int'(err_wdata);
      if (acc) begin
        m_busy = 1; m_cmp = 0; m_cnt = int'(tick_cfg);
      end else begin
        if (idle_tick && m_cnt > 0) m_cnt = m_cnt - 1;
        if (fin) m_cmp = 1;
        if (tdn) m_busy = 0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_cmp();
    int mg = 0;
    foreach (m_go[i]) if (m_go[i]) mg |= (1 << i);
    chk("R7 model busy", int'(busy), int'(m_busy));
    chk("R2 model go_req", int'(go_req), mg);
    chk("R9 model err", int'(err), m_err);
  endtask

  // one clock: inputs held across posedge, compared at negedge, strobes cleared
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    model_cmp();
    launch = 0; done_valid = 0; idle_tick = 0; err_wr = 0; go_ack = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin idle_tick = 1; cyc(); end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); rst = 1; cyc(); cyc(); rst = 0;
    chk("R1 busy", int'(busy), 0);
    chk("R1 go_req", int'(go_req), 0);
    chk("R1 err", int'(err), 0);

    tick_cfg = 2; hart_sel = 1; launch = 1; cyc();
    chk("R2 busy", int'(busy), 1);
    chk("R2 go_req", int'(go_req), 4'b0010);
    ticks(2);
    chk("R7 no completion", int'(busy), 1);
    done_valid = 1; done_hart = 1; cyc();    // go still set: ignored
    ticks(1);
    chk("R6 go pending", int'(busy), 1);
    go_ack = 4'b0010; cyc();
    chk("R5 ack", int'(go_req), 0);
    done_valid = 1; done_hart = 2; cyc();    // not selected
    ticks(1);
    chk("R6 other hart", int'(busy), 1);
    done_valid = 1; done_hart = 1; idle_tick = 1; cyc();
    chk("R7 done+tick same cycle", int'(busy), 1);
    ticks(1);
    chk("R7 busy falls", int'(busy), 0);

    tick_cfg = 3; hart_sel = 2; launch = 1; cyc();
    hart_sel = 3; launch = 1; cyc();
    chk("R4 err", int'(err), 1);
    chk("R4 go kept", int'(go_req), 4'b0100);
    chk("R4 busy kept", int'(busy), 1);
    hart_sel = 2; go_ack = 4'b0100; cyc();
    done_valid = 1; done_hart = 2; cyc();
    ticks(2);
    chk("R7 after 2 of 3", int'(busy), 1);
    ticks(1);
    chk("R7 after 3 of 3", int'(busy), 0);

    hart_sel = 0; launch = 1; cyc();
    chk("R3 refused busy", int'(busy), 0);
    chk("R3 refused go", int'(go_req), 0);
    err_wr = 1; err_wdata = 3'b010; cyc();
    chk("R9 other bit", int'(err), 1);
    err_wr = 1; err_wdata = 3'b001; cyc();
    chk("R9 cleared", int'(err), 0);

    tick_cfg = 0; hart_sel = 0; launch = 1; cyc();
    go_ack = 4'b0001; cyc();
    done_valid = 1; done_hart = 0; cyc();
    chk("R8 before tick", int'(busy), 1);
    ticks(1);
    chk("R8 first tick", int'(busy), 0);

    tick_cfg = 2; launch = 1; idle_tick = 1; cyc();
    go_ack = 4'b0001; cyc();
    done_valid = 1; done_hart = 0; cyc();
    ticks(1);
    chk("R11 one tick", int'(busy), 1);
    ticks(1);
    chk("R11 two ticks", int'(busy), 0);

    launch = 1; go_ack = 4'b0001; cyc();
    chk("R5 launch wins", int'(go_req), 4'b0001);
    launch = 1; err_wr = 1; err_wdata = 3'b111; cyc();
    chk("R10 err set wins", int'(err), 1);
    err_wr = 1; err_wdata = 3'b111; cyc();
    chk("R9 clear again", int'(err), 0);

    rst = 1; cyc(); rst = 0;
    chk("R1 late reset busy", int'(busy), 0);
    chk("R1 late reset go", int'(go_req), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule